// File: doc/BRIEF.md
# Debug Mode Controller

This block decides when a small processor core is halted for debugging and when it resumes. A debug request with a non-zero cause code takes the core into debug mode. The block records three things: the cause, the privilege level the core was running at, and the program counter the core was about to execute. It then tells the core to jump to a fixed debug ROM address at machine privilege. A dedicated return instruction undoes this. It sends the core back to the saved program counter, restores the saved privilege, and clears the cause, because a zero cause is how the block marks that the core is outside debug mode.

Three debug registers hold the saved state: a control word, the saved program counter, and a scratch word. A single-cycle CSR port reads and writes them. Reads are combinational. Writes take effect at the next clock edge.

Every pin is a plain control or status signal. No pin is a stream, so there is no valid/ready handshake and no back-pressure. Each request or instruction is seen for exactly one cycle. The resulting redirect appears as a one-cycle pulse in the following cycle, and the core must act on it in that cycle.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: After reset, `debug_mode_o`, `redirect_o` and `illegal_o` are 0 and `prv_o` is 3 (machine). The control word reads 0x3, and the saved PC and scratch words read 0.
- R2: A request with a non-zero cause, while not in debug mode, produces these results in the next cycle: a one-cycle `redirect_o` pulse, `redirect_pc_o` = ROM_BASE, `prv_o` = 3, and `debug_mode_o` = 1.
- R3: Entry stores three values. The cause goes into control bits [8:6]. The current privilege goes into control bits [1:0]. `cur_pc_i` goes into the saved PC register (address 0x791). The control word is at address 0x790.
- R4: A request is ignored when the block is already in debug mode or when the cause is 0. No redirect occurs and the saved state does not change.
- R5: The return instruction is the exact word 0x79200073 with `insn_valid_i` high. At privilege 3 it produces these results in the next cycle: a redirect to the saved PC, `prv_o` equal to the saved privilege field, and `debug_mode_o` = 0, because the cause is cleared.
- R6: The return word at a privilege below 3 pulses `illegal_o` for one cycle. It causes no redirect and changes no state.
- R7: A word that differs from 0x79200073 in any bit, or the return word with `insn_valid_i` low, has no effect.
- R8: If a valid entry request and a return instruction arrive in the same cycle, the entry wins. The return is discarded and `illegal_o` stays 0.
- R9: `csr_rdata_o` reflects the addressed register in the same cycle. Addresses other than 0x790, 0x791 and 0x792 read 0.
- R10: The scratch word (0x792) and the saved PC are fully writable. In the control word only the privilege field [1:0] is writable, and the cause field cannot be written.
- R11: A CSR write to the saved PC or to the privilege field in the same cycle as an entry is overridden by the values that the entry stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_req_i | input | 1 | Debug request strobe |
| dbg_cause_i | input | CAUSE_W | Cause code for the request (0 = none) |
| cur_pc_i | input | XLEN | PC of the instruction the core would execute next |
| cur_prv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| insn_valid_i | input | 1 | `insn_i` holds a decoded instruction this cycle |
| insn_i | input | 32 | Instruction word |
| csr_addr_i | input | 12 | CSR address |
| csr_we_i | input | 1 | CSR write strobe |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data (combinational) |
| redirect_o | output | 1 | One-cycle pulse: the core jumps and flushes |
| redirect_pc_o | output | XLEN | Jump target, valid with `redirect_o` |
| prv_o | output | 2 | Privilege to adopt, valid with `redirect_o` |
| debug_mode_o | output | 1 | High while the cause field is non-zero |
| illegal_o | output | 1 | One-cycle illegal-instruction pulse |

## Verification
The bound checker checks the following on every cycle: the entry jump, the return exit, the illegal-instruction pulse for an under-privileged return, and the rule that a request made inside debug mode leaves the block in debug mode. It also checks that a redirect and an illegal pulse never occur together. Other behaviour can only be seen through the bench's scenarios. This covers what entry saves and what a return restores, as read back through the CSR port. It also covers near-miss instruction words, the read-only cause field, collisions between entry and a return or a CSR write, and restoring a supervisor privilege that software edited.

// File: rtl/dbgm_pkg.sv
package dbgm_pkg;
  typedef enum logic [1:0] {
    PRV_USR = 2'd0,
    PRV_SUP = 2'd1,
    PRV_RSV = 2'd2,
    PRV_MAC = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    EV_NONE    = 2'd0,
    EV_ENTER   = 2'd1,
    EV_RETURN  = 2'd2,
    EV_ILLEGAL = 2'd3
  } dbg_event_e;

  localparam logic [11:0] ADDR_CTL = 12'h790;
  localparam logic [11:0] ADDR_SPC = 12'h791;
  localparam logic [11:0] ADDR_SCR = 12'h792;

  localparam logic [31:0] RET_WORD = 32'h7920_0073;

  localparam int CTL_PRV_LSB   = 0;
  localparam int CTL_CAUSE_LSB = 6;
endpackage

// File: rtl/dbgm_ret_decode.sv
module dbgm_ret_decode
  import dbgm_pkg::*;
(
  input  logic        insn_valid_i,
  input  logic [31:0] insn_i,
  input  logic [1:0]  prv_i,
  output logic        ret_ok_o,
  output logic        ret_bad_o
);
  logic hit;

  // Exact match on every bit: no don't-care positions.
  assign hit       = insn_valid_i && (insn_i == RET_WORD);
  assign ret_ok_o  = hit && (prv_i == PRV_MAC);
  assign ret_bad_o = hit && (prv_i != PRV_MAC);
endmodule

// File: rtl/dbgm_event_arb.sv
module dbgm_event_arb
  import dbgm_pkg::*;
#(
  parameter int CAUSE_W = 3
) (
  input  logic               req_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               in_debug_i,
  input  logic               ret_ok_i,
  input  logic               ret_bad_i,
  output dbg_event_e         ev_o
);
  logic enter;

  assign enter = req_i && (cause_i != '0) && !in_debug_i;

  // Entry outranks the instruction stream: the instruction is not retired.
  always_comb begin
    if (enter)          ev_o = EV_ENTER;
    else if (ret_ok_i)  ev_o = EV_RETURN;
    else if (ret_bad_i) ev_o = EV_ILLEGAL;
    else                ev_o = EV_NONE;
  end
endmodule

// File: rtl/dbgm_csr_file.sv
module dbgm_csr_file
  import dbgm_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dbg_event_e         ev_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [XLEN-1:0]    cur_pc_i,
  input  logic [1:0]         cur_prv_i,
  input  logic [11:0]        csr_addr_i,
  input  logic               csr_we_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  output logic [XLEN-1:0]    saved_pc_o,
  output logic [1:0]         saved_prv_o,
  output logic               in_debug_o
);
  logic [CAUSE_W-1:0] cause_q;
  logic [1:0]         prv_q;
  logic [XLEN-1:0]    spc_q;
  logic [XLEN-1:0]    scr_q;

  logic wr_ctl, wr_spc, wr_scr;

  assign wr_ctl = csr_we_i && (csr_addr_i == ADDR_CTL);
  assign wr_spc = csr_we_i && (csr_addr_i == ADDR_SPC);
  assign wr_scr = csr_we_i && (csr_addr_i == ADDR_SCR);

  // Cause: hardware-owned, never written by CSR access.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cause_q <= '0;
    else if (ev_i == EV_ENTER)  cause_q <= cause_i;
    else if (ev_i == EV_RETURN) cause_q <= '0;
  end

  // Saved privilege and PC: entry overrides a same-cycle software write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv_q <= PRV_MAC;
      spc_q <= '0;
    end else if (ev_i == EV_ENTER) begin
      prv_q <= cur_prv_i;
      spc_q <= cur_pc_i;
    end else begin
      if (wr_ctl) prv_q <= csr_wdata_i[CTL_PRV_LSB +: 2];
      if (wr_spc) spc_q <= csr_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      scr_q <= '0;
    else if (wr_scr) scr_q <= csr_wdata_i;
  end

  always_comb begin
    csr_rdata_o = '0;
    case (csr_addr_i)
      ADDR_CTL: begin
        csr_rdata_o[CTL_PRV_LSB +: 2]         = prv_q;
        csr_rdata_o[CTL_CAUSE_LSB +: CAUSE_W] = cause_q;
      end
      ADDR_SPC: csr_rdata_o = spc_q;
      ADDR_SCR: csr_rdata_o = scr_q;
      default:  csr_rdata_o = '0;
    endcase
  end

  assign saved_pc_o  = spc_q;
  assign saved_prv_o = prv_q;
  assign in_debug_o  = (cause_q != '0);
endmodule

// File: rtl/dbgm_redirect.sv
module dbgm_redirect
  import dbgm_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] ROM_BASE = 'h800
) (
  input  logic            clk,
  input  logic            rst_n,
  input  dbg_event_e      ev_i,
  input  logic [XLEN-1:0] saved_pc_i,
  input  logic [1:0]      saved_prv_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic [1:0]      prv_o,
  output logic            illegal_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redirect_o    <= 1'b0;
      redirect_pc_o <= '0;
      prv_o         <= PRV_MAC;
      illegal_o     <= 1'b0;
    end else begin
      redirect_o <= (ev_i == EV_ENTER) || (ev_i == EV_RETURN);
      illegal_o  <= (ev_i == EV_ILLEGAL);
      case (ev_i)
        EV_ENTER: begin
          redirect_pc_o <= ROM_BASE;
          prv_o         <= PRV_MAC;
        end
        EV_RETURN: begin
          redirect_pc_o <= saved_pc_i;
          prv_o         <= saved_prv_i;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbgm_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              CAUSE_W  = 3,
  parameter logic [XLEN-1:0] ROM_BASE = 'h800
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dbg_req_i,
  input  logic [CAUSE_W-1:0] dbg_cause_i,
  input  logic [XLEN-1:0]    cur_pc_i,
  input  logic [1:0]         cur_prv_i,
  input  logic               insn_valid_i,
  input  logic [31:0]        insn_i,
  input  logic [11:0]        csr_addr_i,
  input  logic               csr_we_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  output logic               redirect_o,
  output logic [XLEN-1:0]    redirect_pc_o,
  output logic [1:0]         prv_o,
  output logic               debug_mode_o,
  output logic               illegal_o
);
  localparam int CTL_TOP = CTL_CAUSE_LSB + CAUSE_W;

  logic            ret_ok, ret_bad, in_debug;
  logic [XLEN-1:0] saved_pc;
  logic [1:0]      saved_prv;
  dbg_event_e      ev;

  if (CTL_TOP > XLEN) begin : g_bad_width
    initial $error("control word does not fit in XLEN");
  end

  dbgm_ret_decode u_dec (
    .insn_valid_i (insn_valid_i),
    .insn_i       (insn_i),
    .prv_i        (cur_prv_i),
    .ret_ok_o     (ret_ok),
    .ret_bad_o    (ret_bad)
  );

  dbgm_event_arb #(.CAUSE_W(CAUSE_W)) u_arb (
    .req_i      (dbg_req_i),
    .cause_i    (dbg_cause_i),
    .in_debug_i (in_debug),
    .ret_ok_i   (ret_ok),
    .ret_bad_i  (ret_bad),
    .ev_o       (ev)
  );

  dbgm_csr_file #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_csr (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_i        (ev),
    .cause_i     (dbg_cause_i),
    .cur_pc_i    (cur_pc_i),
    .cur_prv_i   (cur_prv_i),
    .csr_addr_i  (csr_addr_i),
    .csr_we_i    (csr_we_i),
    .csr_wdata_i (csr_wdata_i),
    .csr_rdata_o (csr_rdata_o),
    .saved_pc_o  (saved_pc),
    .saved_prv_o (saved_prv),
    .in_debug_o  (in_debug)
  );

  dbgm_redirect #(.XLEN(XLEN), .ROM_BASE(ROM_BASE)) u_rdr (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_i          (ev),
    .saved_pc_i    (saved_pc),
    .saved_prv_i   (saved_prv),
    .redirect_o    (redirect_o),
    .redirect_pc_o (redirect_pc_o),
    .prv_o         (prv_o),
    .illegal_o     (illegal_o)
  );

  assign debug_mode_o = in_debug;
endmodule

// File: rtl/dbgm_checker.sv
module dbgm_checker
  import dbgm_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              CAUSE_W  = 3,
  parameter logic [XLEN-1:0] ROM_BASE = 'h800
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dbg_req_i,
  input logic [CAUSE_W-1:0] dbg_cause_i,
  input logic               insn_valid_i,
  input logic [31:0]        insn_i,
  input logic [1:0]         cur_prv_i,
  input logic               redirect_o,
  input logic [XLEN-1:0]    redirect_pc_o,
  input logic [1:0]         prv_o,
  input logic               debug_mode_o,
  input logic               illegal_o
);
  logic entering, ret_word;

  assign entering = dbg_req_i && (dbg_cause_i != '0) && !debug_mode_o;
  assign ret_word = insn_valid_i && (insn_i == 32'h7920_0073);

  // R2
  entry_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entering |=> (redirect_o && redirect_pc_o == ROM_BASE && prv_o == 2'd3 && debug_mode_o));

  // R4
  stay_in_debug_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (debug_mode_o && !(ret_word && cur_prv_i == 2'd3)) |=> debug_mode_o);

  // R5
  ret_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!entering && ret_word && cur_prv_i == 2'd3) |=> (redirect_o && !debug_mode_o && !illegal_o));

  // R6
  ret_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!entering && ret_word && cur_prv_i != 2'd3) |=> (illegal_o && !redirect_o));

  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(redirect_o && illegal_o));
endmodule

bind dbg_mode_ctrl dbgm_checker #(
  .XLEN(XLEN), .CAUSE_W(CAUSE_W), .ROM_BASE(ROM_BASE)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dbg_req_i     (dbg_req_i),
  .dbg_cause_i   (dbg_cause_i),
  .insn_valid_i  (insn_valid_i),
  .insn_i        (insn_i),
  .cur_prv_i     (cur_prv_i),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .prv_o         (prv_o),
  .debug_mode_o  (debug_mode_o),
  .illegal_o     (illegal_o)
);

// File: tb/sim_dbg_mode_ctrl.sv
module sim_dbg_mode_ctrl;
  localparam logic [31:0] ROM  = 32'h0000_0800;
  localparam logic [31:0] RETW = 32'h7920_0073;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg_req = 1'b0;
  logic [2:0]  dbg_cause = '0;
  logic [31:0] cur_pc = '0;
  logic [1:0]  cur_prv = 2'd3;
  logic        insn_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [11:0] csr_addr = '0;
  logic        csr_we = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        redirect;
  logic [31:0] redirect_pc;
  logic [1:0]  prv;
  logic        dbg_mode;
  logic        illegal;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  dbg_mode_ctrl #(.XLEN(32), .CAUSE_W(3), .ROM_BASE(ROM)) u0 (
    .clk (clk), .rst_n (rst_n),
    .dbg_req_i (dbg_req), .dbg_cause_i (dbg_cause),
    .cur_pc_i (cur_pc), .cur_prv_i (cur_prv),
    .insn_valid_i (insn_valid), .insn_i (insn),
    .csr_addr_i (csr_addr), .csr_we_i (csr_we), .csr_wdata_i (csr_wdata),
    .csr_rdata_o (csr_rdata), .redirect_o (redirect), .redirect_pc_o (redirect_pc),
    .prv_o (prv), .debug_mode_o (dbg_mode), .illegal_o (illegal)
  );

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    csr_addr = a;
    #1;
    d = csr_rdata;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    step();
    csr_we = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 debug_mode", {31'b0, dbg_mode}, 32'd0);
    chk("R1 redirect", {31'b0, redirect}, 32'd0);
    chk("R1 illegal", {31'b0, illegal}, 32'd0);
    chk("R1 prv", {30'b0, prv}, 32'd3);
    rd(12'h790, d); chk("R1 ctl", d, 32'h3);
    rd(12'h791, d); chk("R1 spc", d, 32'h0);
    rd(12'h792, d); chk("R1 scratch", d, 32'h0);
  endtask

  task automatic t_csr;
    logic [31:0] d;
    wr(12'h792, 32'hDEAD_BEEF);
    rd(12'h792, d); chk("R10 scratch rw", d, 32'hDEAD_BEEF);
    wr(12'h791, 32'h0000_1234);
    rd(12'h791, d); chk("R10 spc rw", d, 32'h0000_1234);
    wr(12'h790, 32'hFFFF_FFFF);
    rd(12'h790, d); chk("R10 cause read-only", d, 32'h3);
    chk("R10 no debug by write", {31'b0, dbg_mode}, 32'd0);
    wr(12'h790, 32'h1);
    rd(12'h790, d); chk("R10 prv field write", d, 32'h1);
    rd(12'h7A0, d); chk("R9 unmapped reads 0", d, 32'h0);
  endtask

  task automatic t_enter;
    logic [31:0] d;
    cur_pc = 32'h4000_1000; cur_prv = 2'd0; dbg_req = 1'b1; dbg_cause = 3'd2;
    step();
    dbg_req = 1'b0; dbg_cause = '0; cur_prv = 2'd3;
    chk("R2 redirect", {31'b0, redirect}, 32'd1);
    chk("R2 rom pc", redirect_pc, ROM);
    chk("R2 prv machine", {30'b0, prv}, 32'd3);
    chk("R2 debug_mode", {31'b0, dbg_mode}, 32'd1);
    rd(12'h790, d); chk("R3 ctl cause/prv", d, 32'h80);
    rd(12'h791, d); chk("R3 saved pc", d, 32'h4000_1000);
    step();
    chk("R2 redirect one cycle", {31'b0, redirect}, 32'd0);
  endtask

  task automatic t_ignore_in_debug;
    logic [31:0] d;
    cur_pc = 32'h0000_0999; cur_prv = 2'd1; dbg_req = 1'b1; dbg_cause = 3'd5;
    step();
    dbg_req = 1'b0; dbg_cause = '0; cur_prv = 2'd3;
    chk("R4 no redirect in debug", {31'b0, redirect}, 32'd0);
    rd(12'h790, d); chk("R4 ctl unchanged", d, 32'h80);
    rd(12'h791, d); chk("R4 spc unchanged", d, 32'h4000_1000);
  endtask

  task automatic t_illegal;
    logic [31:0] d;
    cur_prv = 2'd1; insn_valid = 1'b1; insn = RETW;
    step();
    insn_valid = 1'b0; cur_prv = 2'd3;
    chk("R6 illegal pulse", {31'b0, illegal}, 32'd1);
    chk("R6 no redirect", {31'b0, redirect}, 32'd0);
    chk("R6 still debug", {31'b0, dbg_mode}, 32'd1);
    rd(12'h790, d); chk("R6 ctl unchanged", d, 32'h80);
    step();
    chk("R6 illegal one cycle", {31'b0, illegal}, 32'd0);
  endtask

  task automatic t_near_miss;
    insn_valid = 1'b1; insn = 32'h7920_0077; cur_prv = 2'd3;
    step();
    chk("R7 near-miss no redirect", {31'b0, redirect}, 32'd0);
    chk("R7 near-miss no illegal", {31'b0, illegal}, 32'd0);
    insn_valid = 1'b0; insn = RETW;
    step();
    chk("R7 invalid word no redirect", {31'b0, redirect}, 32'd0);
    chk("R7 still debug", {31'b0, dbg_mode}, 32'd1);
  endtask

  task automatic t_return(input logic [31:0] exp_pc, input logic [1:0] exp_prv);
    insn_valid = 1'b1; insn = RETW; cur_prv = 2'd3;
    step();
    insn_valid = 1'b0;
    chk("R5 redirect", {31'b0, redirect}, 32'd1);
    chk("R5 pc restored", redirect_pc, exp_pc);
    chk("R5 prv restored", {30'b0, prv}, {30'b0, exp_prv});
    chk("R5 debug cleared", {31'b0, dbg_mode}, 32'd0);
    chk("R5 no illegal", {31'b0, illegal}, 32'd0);
  endtask

  task automatic t_zero_cause;
    dbg_req = 1'b1; dbg_cause = 3'd0; cur_pc = 32'h0000_0444;
    step();
    dbg_req = 1'b0;
    chk("R4 zero cause no redirect", {31'b0, redirect}, 32'd0);
    chk("R4 zero cause no debug", {31'b0, dbg_mode}, 32'd0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    cur_pc = 32'h0000_2000; cur_prv = 2'd3; dbg_req = 1'b1; dbg_cause = 3'd3;
    insn_valid = 1'b1; insn = RETW;
    csr_addr = 12'h791; csr_wdata = 32'h0000_5555; csr_we = 1'b1;
    step();
    dbg_req = 1'b0; dbg_cause = '0; insn_valid = 1'b0; csr_we = 1'b0;
    chk("R8 entry wins redirect", redirect_pc, ROM);
    chk("R8 entered debug", {31'b0, dbg_mode}, 32'd1);
    chk("R8 return discarded", {31'b0, illegal}, 32'd0);
    rd(12'h790, d); chk("R3 ctl after collide", d, 32'hC3);
    rd(12'h791, d); chk("R11 spc write overridden", d, 32'h0000_2000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_csr();
    t_enter();
    t_ignore_in_debug();
    t_illegal();
    t_near_miss();
    t_return(32'h4000_1000, 2'd0);
    t_zero_cause();
    t_collide();
    wr(12'h790, 32'h1);
    t_return(32'h0000_2000, 2'd1);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule